// File: doc/BRIEF.md
# Masked Bit-Pattern Execution Unit

This unit executes one parameterised bitmask operation on a 64-bit source value. Three selectable pieces are built from the source. The first is the source itself or its complement. The second is one of four arithmetic variants of the source. The third is the logic operator that merges the first two. The merged value then passes through a predicate-style mask. A single mode field therefore covers a whole family of fixed bit tricks, such as clearing the lowest set bit, isolating the lowest set bit, or building a mask up to the lowest set bit.

The unit takes a 32-bit instruction word together with the two operand values already read from the register file. A small decoder pulls the mode field, the keep flag, the mask register index and the destination index out of the word. The decoder drives the datapath through a struct of control strobes. The result, the write enable, the illegal-encoding flag and the destination index are registered and appear one clock after an issue. Register-file access, trap handling and any looping over vector elements are left to the surrounding pipeline.

Top module: `bitmask_pattern_unit`

## Requirements
- R1: Fields are decoded from `instrWord`: destination index = bits [25:21], mask register index = bits [15:11], mode `bm` = bits [10:6] with `bm[0]` at bit 6, keep flag = bit 5. `destReg` reports the destination index of the issued word.
- R2: `bm[4]` = 0 uses the source x as the first piece; `bm[4]` = 1 uses ~x.
- R3: `bm[1:0]` selects the merge operator: 00 = OR, 01 = AND, 10 = XOR.
- R4: `bm[3:2]` selects the second piece: 00 = x+1, 01 = x-1, 10 = ~(x+1), 11 = (~x)+1. All arithmetic wraps modulo 2^64, so all-ones plus one is zero and zero minus one is all-ones.
- R5: When the mask register index is zero, the mask is all ones and `rbValue` is ignored. Otherwise the mask is `rbValue`.
- R6: With the keep flag at 1, every result bit outside the mask equals the matching `raValue` bit.
- R7: With the keep flag at 0, every result bit outside the mask is 0. Bits inside the mask carry the merged value.
- R8: `bm[1:0]` = 11 is reserved. It sets `illegalOp`, clears `writeEn` and drives `rsValue` to zero.
- R9: One clock after a cycle with `issueValid` high, `doneValid` is high and `rsValue`, `writeEn`, `illegalOp` and `destReg` describe that issue.
- R10: While `rstN` is low, all outputs are zero.
- R11: One clock after a cycle with `issueValid` low, `doneValid`, `writeEn` and `illegalOp` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction and operands are valid this cycle |
| instrWord | input | 32 | Instruction word carrying the fields |
| raValue | input | 64 | Source operand value |
| rbValue | input | 64 | Mask operand value |
| doneValid | output | 1 | Registered result is valid |
| rsValue | output | 64 | Registered result |
| writeEn | output | 1 | Result may be written to the destination |
| illegalOp | output | 1 | Reserved encoding was issued |
| destReg | output | 5 | Destination register index |

## Verification
All outputs pass through one register stage, so every result belongs to the issue one rising edge earlier. The bench drives each issue on a falling edge and samples 1 ns after the next rising edge, then compares against a bench-side model of the mode field. Idle cycles are sampled the same way, one edge after `issueValid` drops. Directed words cover the lowest-set-bit idioms, the wrap cases and the reserved encoding. Seeded random words and operands fill in the rest of the mode space.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int MODE_W    = 5;
  // field positions (little-endian index into the 32-bit word)
  localparam int DEST_LSB  = 21;
  localparam int MASK_LSB  = 11;
  localparam int MODE_LSB  = 6;
  localparam int KEEP_BIT  = 5;

  typedef enum logic [1:0] {
    COMB_OR  = 2'b00,
    COMB_AND = 2'b01,
    COMB_XOR = 2'b10,
    COMB_RSV = 2'b11
  } combOp_e;

  typedef enum logic [1:0] {
    AR_INC  = 2'b00,
    AR_DEC  = 2'b01,
    AR_NINC = 2'b10,
    AR_NEG  = 2'b11
  } arith_e;

  typedef struct packed {
    logic                 invertSrc;
    combOp_e              combOp;
    arith_e               arithForm;
    logic                 keepOuter;
    logic                 maskAll;
    logic                 illegal;
    logic [REG_IDX_W-1:0] destIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobes_t       strobes
);
  logic [MODE_W-1:0]    modeField;
  logic [REG_IDX_W-1:0] maskIdx;

  assign modeField = instrWord[MODE_LSB +: MODE_W];
  assign maskIdx   = instrWord[MASK_LSB +: REG_IDX_W];

  always_comb begin
    strobes.invertSrc = modeField[4];
    strobes.combOp    = combOp_e'(modeField[1:0]);
    strobes.arithForm = arith_e'(modeField[3:2]);
    strobes.keepOuter = instrWord[KEEP_BIT];
    strobes.maskAll   = (maskIdx == '0);
    strobes.illegal   = (modeField[1:0] == 2'b11);
    strobes.destIdx   = instrWord[DEST_LSB +: REG_IDX_W];
  end
endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  ctrlStrobes_t         strobes,
  input  logic [DATA_W-1:0]    raValue,
  input  logic [DATA_W-1:0]    rbValue,
  output logic                 doneValid,
  output logic [DATA_W-1:0]    rsValue,
  output logic                 writeEn,
  output logic                 illegalOp,
  output logic [REG_IDX_W-1:0] destReg
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] firstPiece, secondPiece, merged, maskVec, finalVal;

  assign firstPiece = strobes.invertSrc ? ~raValue : raValue;

  always_comb begin
    unique case (strobes.arithForm)
      AR_INC:  secondPiece = raValue + ONE;
      AR_DEC:  secondPiece = raValue - ONE;
      AR_NINC: secondPiece = ~(raValue + ONE);
      default: secondPiece = (~raValue) + ONE;
    endcase
  end

  always_comb begin
    unique case (strobes.combOp)
      COMB_OR:  merged = firstPiece | secondPiece;
      COMB_AND: merged = firstPiece & secondPiece;
      COMB_XOR: merged = firstPiece ^ secondPiece;
      default:  merged = '0;
    endcase
  end

  assign maskVec = strobes.maskAll ? '1 : rbValue;

  for (genvar b = 0; b < DATA_W; b++) begin : g_merge
    assign finalVal[b] = maskVec[b] ? merged[b]
                                    : (strobes.keepOuter & raValue[b]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      rsValue   <= '0;
      writeEn   <= 1'b0;
      illegalOp <= 1'b0;
      destReg   <= '0;
    end else begin
      doneValid <= issueValid;
      writeEn   <= issueValid & ~strobes.illegal;
      illegalOp <= issueValid & strobes.illegal;
      if (issueValid) begin
        rsValue <= strobes.illegal ? '0 : finalVal;
        destReg <= strobes.destIdx;
      end
    end
  end
endmodule

// File: rtl/bitmask_pattern_unit.sv
module bitmask_pattern_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [DATA_W-1:0]    raValue,
  input  logic [DATA_W-1:0]    rbValue,
  output logic                 doneValid,
  output logic [DATA_W-1:0]    rsValue,
  output logic                 writeEn,
  output logic                 illegalOp,
  output logic [REG_IDX_W-1:0] destReg
);
  ctrlStrobes_t strobes;

  bmu_ctrl uCtrl (
    .instrWord (instrWord),
    .strobes   (strobes)
  );

  bmu_datapath #(.DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .strobes    (strobes),
    .raValue    (raValue),
    .rbValue    (rbValue),
    .doneValid  (doneValid),
    .rsValue    (rsValue),
    .writeEn    (writeEn),
    .illegalOp  (illegalOp),
    .destReg    (destReg)
  );
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic [INSTR_W-1:0]   instrWord,
  input logic [DATA_W-1:0]    raValue,
  input logic [DATA_W-1:0]    rbValue,
  input logic                 doneValid,
  input logic [DATA_W-1:0]    rsValue,
  input logic                 writeEn,
  input logic                 illegalOp,
  input logic [REG_IDX_W-1:0] destReg
);
  logic legalWord, maskedWord;
  assign legalWord  = (instrWord[MODE_LSB +: 2] != 2'b11);
  assign maskedWord = (instrWord[MASK_LSB +: REG_IDX_W] != '0);

  p_keep_outside_r6: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && legalWord && maskedWord && instrWord[KEEP_BIT]
    |=> ((rsValue ^ $past(raValue)) & ~$past(rbValue)) == '0);

  p_zero_outside_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && maskedWord && !instrWord[KEEP_BIT]
    |=> (rsValue & ~$past(rbValue)) == '0);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !legalWord |=> illegalOp && !writeEn && rsValue == '0);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> doneValid && destReg == $past(instrWord[DEST_LSB +: REG_IDX_W]));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({writeEn, illegalOp}));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> !doneValid && !writeEn && !illegalOp);
endmodule

bind bitmask_pattern_unit bmu_checker #(.DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .instrWord  (instrWord),
  .raValue    (raValue),
  .rbValue    (rbValue),
  .doneValid  (doneValid),
  .rsValue    (rsValue),
  .writeEn    (writeEn),
  .illegalOp  (illegalOp),
  .destReg    (destReg)
);

// File: tb/bitmask_pattern_unit_test.sv
`timescale 1ns/1ps
module bitmask_pattern_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] raValue = '0;
  logic [63:0] rbValue = '0;
  logic        doneValid, writeEn, illegalOp;
  logic [63:0] rsValue;
  logic [4:0]  destReg;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bitmask_pattern_unit uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .raValue(raValue), .rbValue(rbValue), .doneValid(doneValid),
    .rsValue(rsValue), .writeEn(writeEn), .illegalOp(illegalOp), .destReg(destReg)
  );

  function automatic logic [31:0] mkWord(input logic [4:0] dst, input logic [4:0] mIdx,
                                         input logic [4:0] mode, input logic keep);
    return {6'd0, dst, 5'd3, mIdx, mode, keep, 5'd0};
  endfunction

  function automatic logic [63:0] refModel(input logic [31:0] w, input logic [63:0] ra,
                                           input logic [63:0] rb);
    logic [4:0]  m;
    logic [63:0] a, c, u, msk;
    m = w[10:6];
    a = m[4] ? ~ra : ra;
    case (m[3:2])
      2'd0: c = ra + 64'd1;
      2'd1: c = ra - 64'd1;
      2'd2: c = ~(ra + 64'd1);
      default: c = (~ra) + 64'd1;
    endcase
    case (m[1:0])
      2'd0: u = a | c;
      2'd1: u = a & c;
      2'd2: u = a ^ c;
      default: return 64'd0;
    endcase
    msk = (w[15:11] == 5'd0) ? '1 : rb;
    return (u & msk) | (w[5] ? (ra & ~msk) : 64'd0);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [31:0] w, input logic [63:0] ra,
                       input logic [63:0] rb, input logic [63:0] expRes);
    logic bad;
    bad = (w[7:6] == 2'b11);
    @(negedge clk);
    issueValid = 1'b1; instrWord = w; raValue = ra; rbValue = rb;
    @(posedge clk); #1;
    check(req, rsValue, expRes);
    check("R9 doneValid", {63'd0, doneValid}, 64'd1);
    check("R8 writeEn", {63'd0, writeEn}, {63'd0, !bad});
    check("R8 illegalOp", {63'd0, illegalOp}, {63'd0, bad});
    check("R1 destReg", {59'd0, destReg}, {59'd0, w[25:21]});
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [63:0] ra, rb;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 rsValue", rsValue, 64'd0);
    check("R10 flags", {59'd0, doneValid, writeEn, illegalOp, 2'b0}, 64'd0);
    check("R10 destReg", {59'd0, destReg}, 64'd0);
    @(negedge clk); rstN = 1'b1;

    // R3/R4 clear lowest set bit: AND with x-1, mode 00101
    runOp("R3 clear-lowest", mkWord(5'd7, 5'd0, 5'b00101, 1'b0), 64'h58, 64'h0, 64'h50);
    // R4 isolate lowest set bit: AND with (~x)+1, mode 01101
    runOp("R4 isolate-lowest", mkWord(5'd9, 5'd0, 5'b01101, 1'b0), 64'h58, 64'h0, 64'h08);
    runOp("R4 clear-lowest zero", mkWord(5'd1, 5'd0, 5'b00101, 1'b0), 64'h0, 64'h0, 64'h0);
    // R4 wrap: all ones + 1 = 0, OR keeps all ones; XOR too
    runOp("R4 inc wrap or", mkWord(5'd2, 5'd0, 5'b00000, 1'b0), '1, 64'h0, '1);
    runOp("R3 xor wrap", mkWord(5'd2, 5'd0, 5'b00010, 1'b0), '1, 64'h0, '1);
    // R4 zero - 1 wraps to all ones
    runOp("R4 dec wrap", mkWord(5'd4, 5'd0, 5'b00100, 1'b0), 64'h0, 64'h0, '1);
    // R2 invert: ~x AND (x+1) on 0x57 = isolate lowest clear bit = 0x08
    runOp("R2 invert src", mkWord(5'd5, 5'd0, 5'b10001, 1'b0), 64'h57, 64'h0, 64'h08);
    // R5 mask index zero ignores rbValue
    runOp("R5 mask all", mkWord(5'd6, 5'd0, 5'b00101, 1'b0), 64'hF0F0, 64'h0, 64'hF0E0);
    // R6 keep outside mask
    runOp("R6 keep", mkWord(5'd8, 5'd12, 5'b00000, 1'b1), 64'hAAAA_AAAA_AAAA_AAAA,
          64'h0000_0000_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAB);
    // R7 zero outside mask
    runOp("R7 zero", mkWord(5'd8, 5'd12, 5'b00000, 1'b0), 64'hAAAA_AAAA_AAAA_AAAA,
          64'h0000_0000_FFFF_FFFF, 64'h0000_0000_AAAA_AAAB);
    // R8 reserved
    runOp("R8 reserved", mkWord(5'd11, 5'd0, 5'b00011, 1'b1), 64'h1234, 64'h0, 64'h0);

    // R11 idle
    @(negedge clk); issueValid = 1'b0;
    @(posedge clk); #1;
    check("R11 idle flags", {61'd0, doneValid, writeEn, illegalOp}, 64'd0);

    // random mix: R1..R8 against model
    for (int i = 0; i < 400; i++) begin
      w = $urandom;
      if ($urandom_range(3) == 0) w[15:11] = 5'd0;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      case ($urandom_range(7))
        0: ra = '0;
        1: ra = '1;
        default: ;
      endcase
      runOp("R7 random", w, ra, rb, refModel(w, ra, rb));
    end

    @(negedge clk); issueValid = 1'b0;
    @(posedge clk); #1;
    check("R11 idle end", {61'd0, doneValid, writeEn, illegalOp}, 64'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule